// File: doc/BRIEF.md
# Synchronous Serial Port (Master/Slave, 8-bit)

This block moves one byte at a time over a three-wire clocked serial link: a clock line, a data output and a data input. A single buffer port both launches a transmission and returns the last received byte. As master the block generates the serial clock, either from fixed divisions of the system clock or by toggling once per pulse of an external period-timer match. As slave it follows a clock from the pin. In slave mode an active-low select input can gate the transfer.

Data leaves most significant bit first. The output bit changes on one clock edge and the input bit is sampled on the opposite edge. A polarity control sets the idle level and which physical edge does which job. Each completed byte sets a done flag. Status flags also report a write that arrives while a byte is still shifting, and a new byte that lands while the previous one is unread. Pad multiplexing is left outside: the block only reports whether it owns its pins.

Top module: `ssp_port`

## Requirements
- R1: In modes 4'b0000, 4'b0001 and 4'b0010 the block is master, and each SCK half period lasts 2, 8 and 32 system clocks respectively. A transfer makes 16 SCK transitions and leaves SCK at its idle level.
- R2: In mode 4'b0011 the block is master, and SCK toggles once for each `tmr_match` pulse seen during a transfer. A byte therefore takes 16 pulses.
- R3: Mode 4'b0100 is slave with select qualification. While `ss_n` is high, SCK edges are ignored, the bit count is cleared and `sdo_oe` is low. Mode 4'b0101 is slave with `ss_n` ignored and `sdo_oe` high.
- R4: With `cfg_cpol`=0, SCK idles low, the output changes on the rising edge and the input is sampled on the falling edge. With `cfg_cpol`=1 all three are inverted.
- R5: Bits are sent and received MSB first, 8 per transfer, and the received byte appears on `buf_rdata`.
- R6: With `cfg_en`=0, `port_en`, `sck_oe` and `sdo_oe` are low, no transfer runs and buffer writes are ignored.
- R7: A buffer write while a byte is shifting sets `wcol`, and the written byte is discarded.
- R8: When a byte completes while `full` is still set, `ovf` is set and `buf_rdata` keeps the old byte.
- R9: A completed byte sets `done`, and also sets `full` when no overflow occurs. `buf_rd` clears `full`. `flag_clr` bit 0, bit 1 and bit 2 clear `done`, `wcol` and `ovf`.
- R10: After reset all flags are 0 and SCK is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Port enable |
| cfg_mode | input | 4 | Master/slave and clock-source select |
| cfg_cpol | input | 1 | Clock polarity |
| buf_wr | input | 1 | Write strobe for the transmit byte |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Read strobe, clears full |
| buf_rdata | output | 8 | Last received byte |
| flag_clr | input | 3 | Clear done / wcol / ovf (bits 0/1/2) |
| tmr_match | input | 1 | Period-timer match pulse |
| sck_in | input | 1 | Serial clock from the pin (slave) |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock to the pin |
| sck_oe | output | 1 | Serial clock drive enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data drive enable |
| port_en | output | 1 | Port owns its pins |
| done | output | 1 | Transfer complete flag |
| wcol | output | 1 | Write collision flag |
| ovf | output | 1 | Receive overflow flag |
| full | output | 1 | Receive buffer full |

## Verification
Master transfers run with byte pairs such as A5/3C, 5A/C3 and 81/7E, which are complementary and asymmetric patterns. A bit-order or edge swap therefore changes the sent and received bytes. The transfers also run at all three divider rates and with both polarities, so SCK is compared clock by clock against a behavioural count of half periods. The timer-driven mode counts SCK transitions against match pulses, including extra pulses after the byte ends. Slave transfers show that the select line is ignored in one mode, and that in the other it blocks edges and restarts a half-received byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam logic [3:0] MODE_MDIV_A = 4'b0000;
    localparam logic [3:0] MODE_MDIV_B = 4'b0001;
    localparam logic [3:0] MODE_MDIV_C = 4'b0010;
    localparam logic [3:0] MODE_MTMR   = 4'b0011;
    localparam logic [3:0] MODE_SLV_SS = 4'b0100;
    localparam logic [3:0] MODE_SLV    = 4'b0101;

    function automatic logic mode_is_master(input logic [3:0] m);
        return m[3:2] == 2'b00;
    endfunction

    function automatic logic mode_is_slave(input logic [3:0] m);
        return (m == MODE_SLV_SS) || (m == MODE_SLV);
    endfunction
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       tmr_match,
    output logic       tick
);
    localparam int MAX_HALF = BASE_HALF << 4;
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim   = CNT_W'((BASE_HALF << (2 * int'(sel))) - 1);
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (sel == 2'b11) begin
            tick  = run && tmr_match;
            cnt_d = '0;
        end else if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == lim) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb sr_d[g] = din;
        end else begin : g_next
            always_comb sr_d[g] = sr_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BASE_HALF   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_cpol,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic [2:0]        flag_clr,
    input  logic              tmr_match,
    input  logic              sck_in,
    input  logic              ss_n,
    input  logic              sdi,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              port_en,
    output logic              done,
    output logic              wcol,
    output logic              ovf,
    output logic              full
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              ph;
        logic              busy;
        logic [CNT_W-1:0]  bits;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rbuf;
        logic              prev;
        logic              done;
        logic              wcol;
        logic              ovf;
        logic              full;
    } st_t;

    st_t  st_d, st_q;
    logic tick, sck_s;
    logic is_m, is_s, ss_block, lead, trail, shifting, last_bit;
    logic [DATA_W-1:0] rx_next;

    ssp_clkgen #(.BASE_HALF(BASE_HALF)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.busy && is_m),
        .sel       (cfg_mode[1:0]),
        .tmr_match (tmr_match),
        .tick      (tick)
    );

    ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sck_in),
        .dout  (sck_s)
    );

    always_comb begin
        st_d     = st_q;
        is_m     = cfg_en && mode_is_master(cfg_mode);
        is_s     = cfg_en && mode_is_slave(cfg_mode);
        ss_block = (cfg_mode == MODE_SLV_SS) && ss_n;
        lead     = 1'b0;
        trail    = 1'b0;
        st_d.prev = sck_s;

        if (is_m) begin
            if (tick && st_q.busy) begin
                lead    = !st_q.ph;
                trail   = st_q.ph;
                st_d.ph = !st_q.ph;
            end
        end else if (is_s && !ss_block && (sck_s != st_q.prev)) begin
            lead  = (sck_s != cfg_cpol);
            trail = (sck_s == cfg_cpol);
        end

        shifting = is_m ? st_q.busy : (st_q.bits != '0);
        last_bit = (st_q.bits == CNT_W'(DATA_W - 1));
        rx_next  = {st_q.rx[DATA_W-2:0], sdi};

        if (flag_clr[0]) st_d.done = 1'b0;
        if (flag_clr[1]) st_d.wcol = 1'b0;
        if (flag_clr[2]) st_d.ovf  = 1'b0;
        if (buf_rd)      st_d.full = 1'b0;

        if (buf_wr && (is_m || is_s)) begin
            if (shifting) begin
                st_d.wcol = 1'b1;
            end else begin
                st_d.tx = buf_wdata;
                if (is_m) begin
                    st_d.busy = 1'b1;
                    st_d.ph   = 1'b0;
                end
            end
        end

        if (lead && (st_q.bits != '0))
            st_d.tx = {st_q.tx[DATA_W-2:0], 1'b0};

        if (trail) begin
            st_d.rx = rx_next;
            if (last_bit) begin
                st_d.bits = '0;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.full && !buf_rd) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.rbuf = rx_next;
                    st_d.full = 1'b1;
                end
            end else begin
                st_d.bits = st_q.bits + 1'b1;
            end
        end

        if (!cfg_en || (is_s && ss_block)) st_d.bits = '0;
        if (!is_m) begin
            st_d.busy = 1'b0;
            st_d.ph   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_rdata = st_q.rbuf;
    assign sck_out   = cfg_cpol ^ (is_m && st_q.ph);
    assign sck_oe    = is_m;
    assign sdo       = st_q.tx[DATA_W-1];
    assign sdo_oe    = is_m || (is_s && !ss_block);
    assign port_en   = cfg_en;
    assign done      = st_q.done;
    assign wcol      = st_q.wcol;
    assign ovf       = st_q.ovf;
    assign full      = st_q.full;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic [3:0] cfg_mode,
    input logic       cfg_cpol,
    input logic       ss_n,
    input logic       buf_wr,
    input logic       sck_out,
    input logic       done,
    input logic       wcol,
    input logic       ovf,
    input logic       full,
    input logic       tick
);
    // R1
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_mode[3:2] == 2'b00 && !tick) |=>
        ($stable(sck_out ^ cfg_cpol) || !$stable(cfg_mode) || !$stable(cfg_en)));

    // R3
    ss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_mode == 4'b0100 && ss_n) |=> !$rose(done));

    // R6
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !$rose(done));

    // R7
    wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(buf_wr));

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(full));

    // R9
    full_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> done);
endmodule

bind ssp_port ssp_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_mode (cfg_mode),
    .cfg_cpol (cfg_cpol),
    .ss_n     (ss_n),
    .buf_wr   (buf_wr),
    .sck_out  (sck_out),
    .done     (done),
    .wcol     (wcol),
    .ovf      (ovf),
    .full     (full),
    .tick     (tick)
);

// File: tb/ssp_port_test.sv
`timescale 1ns/1ps
module ssp_port_test;
    logic clk = 0, rst_n = 0;
    logic cfg_en = 0, cfg_cpol = 0;
    logic [3:0] cfg_mode = 4'b0000;
    logic buf_wr = 0, buf_rd = 0;
    logic [7:0] buf_wdata = 0;
    logic [2:0] flag_clr = 0;
    logic tmr_match = 0, sck_in = 0, ss_n = 1, sdi = 0;
    logic [7:0] buf_rdata;
    logic sck_out, sck_oe, sdo, sdo_oe, port_en, done, wcol, ovf, full;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    ssp_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_cpol(cfg_cpol), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .buf_rdata(buf_rdata), .flag_clr(flag_clr),
        .tmr_match(tmr_match), .sck_in(sck_in), .ss_n(ss_n), .sdi(sdi),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .port_en(port_en), .done(done), .wcol(wcol), .ovf(ovf), .full(full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic clear_all();
        buf_rd = 1; flag_clr = 3'b111;
        @(negedge clk);
        buf_rd = 0; flag_clr = 3'b000;
    endtask

    // Master transfer; the model counts elapsed half periods behaviourally
    task automatic mxfer(input logic [7:0] txb, input logic [7:0] devb,
                         input int half, input bit inject, output logic [7:0] got);
        logic [7:0] dev;
        logic prev;
        int tog;
        dev = devb; got = 0; sdi = dev[7];
        buf_wdata = txb; buf_wr = 1;
        @(negedge clk);
        buf_wr = 0; prev = sck_out;
        for (int k = 0; k <= 16 * half + 2; k++) begin
            tog = k / half;
            if (tog > 16) tog = 16;
            chk(sck_out == (cfg_cpol ^ tog[0]), "R1 R4 sck level", sck_out, cfg_cpol ^ tog[0]);
            if (sck_out != prev && sck_out == cfg_cpol) begin
                got = {got[6:0], sdo};
                dev = {dev[6:0], 1'b0};
                sdi = dev[7];
            end
            prev = sck_out;
            if (inject && k == 5) begin buf_wdata = 8'hFF; buf_wr = 1; end
            else buf_wr = 0;
            @(negedge clk);
        end
    endtask

    // Bench acts as master with polarity 0
    task automatic sxfer(input logic [7:0] din, input int nbits, output logic [7:0] got);
        got = 0;
        for (int i = 0; i < nbits; i++) begin
            sdi = din[7 - i];
            sck_in = 1;
            repeat (8) @(negedge clk);
            got = {got[6:0], sdo};
            sck_in = 0;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        int toggles;
        logic prev;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 0 && wcol == 0 && ovf == 0 && full == 0, "R10 flags", {done, wcol, ovf, full}, 0);
        chk(sck_out == 0, "R10 sck idle", sck_out, 0);
        rst_n = 1;
        @(negedge clk);
        // R6 disabled pins
        chk(!port_en && !sck_oe && !sdo_oe, "R6 pins released", {port_en, sck_oe, sdo_oe}, 0);

        // R1 R4 R5 R7 R9 divide-by-4 master
        cfg_en = 1; cfg_mode = 4'b0000; cfg_cpol = 0;
        @(negedge clk);
        mxfer(8'hA5, 8'h3C, 2, 1, got);
        chk(got == 8'hA5, "R5 R7 sent byte", got, 8'hA5);
        chk(buf_rdata == 8'h3C, "R5 received byte", buf_rdata, 8'h3C);
        chk(done && full && !ovf, "R9 done/full", {done, full, ovf}, 3'b110);
        chk(wcol == 1, "R7 collision flag", wcol, 1);
        clear_all();
        chk(!full && !done && !wcol, "R9 read/clear", {full, done, wcol}, 0);

        // R1 R4 divide-by-16 with inverted polarity
        cfg_mode = 4'b0001; cfg_cpol = 1;
        @(negedge clk);
        mxfer(8'h5A, 8'hC3, 8, 0, got);
        chk(got == 8'h5A, "R4 R5 sent byte", got, 8'h5A);
        chk(buf_rdata == 8'hC3, "R4 received byte", buf_rdata, 8'hC3);
        flag_clr = 3'b001; @(negedge clk); flag_clr = 0;

        // R1 R8 divide-by-64 while buffer still full
        cfg_mode = 4'b0010;
        mxfer(8'h81, 8'h7E, 32, 0, got);
        chk(got == 8'h81, "R1 sent byte", got, 8'h81);
        chk(ovf == 1 && done == 1, "R8 overflow flag", {ovf, done}, 2'b11);
        chk(buf_rdata == 8'hC3, "R8 old byte kept", buf_rdata, 8'hC3);
        clear_all();

        // R2 timer-driven clock
        cfg_mode = 4'b0011; cfg_cpol = 0;
        buf_wdata = 8'h3C; buf_wr = 1; @(negedge clk); buf_wr = 0;
        toggles = 0; prev = sck_out;
        for (int c = 0; c < 150; c++) begin
            tmr_match = (c % 6 == 0);
            @(negedge clk);
            if (sck_out != prev) toggles++;
            prev = sck_out;
        end
        tmr_match = 0;
        chk(toggles == 16, "R2 toggle count", toggles, 16);
        chk(done == 1 && sck_out == 0, "R2 completion", {done, sck_out}, 2'b10);
        clear_all();

        // R3 R5 slave without select
        cfg_mode = 4'b0101; ss_n = 1; sck_in = 0;
        repeat (4) @(negedge clk);
        buf_wdata = 8'h4D; buf_wr = 1; @(negedge clk); buf_wr = 0;
        chk(sdo_oe == 1 && sck_oe == 0, "R3 slave drive", {sdo_oe, sck_oe}, 2'b10);
        sxfer(8'h96, 8, got);
        chk(got == 8'h4D, "R3 R5 slave sent", got, 8'h4D);
        chk(buf_rdata == 8'h96 && done, "R3 R5 slave received", buf_rdata, 8'h96);
        clear_all();

        // R3 slave with select: blocked while high
        cfg_mode = 4'b0100; ss_n = 1;
        @(negedge clk);
        chk(sdo_oe == 0, "R3 sdo released", sdo_oe, 0);
        sxfer(8'hFF, 8, got);
        chk(done == 0 && full == 0, "R3 edges ignored", {done, full}, 0);
        ss_n = 0; @(negedge clk);
        sxfer(8'hE0, 3, got);
        ss_n = 1; repeat (4) @(negedge clk);
        ss_n = 0; repeat (4) @(negedge clk);
        sxfer(8'h2B, 8, got);
        chk(buf_rdata == 8'h2B && !ovf, "R3 restart after select", buf_rdata, 8'h2B);
        clear_all();
        ss_n = 1;

        // R6 writes ignored while disabled
        cfg_en = 0; cfg_mode = 4'b0000;
        @(negedge clk);
        chk(!port_en && !sck_oe && !sdo_oe, "R6 disabled pins", {port_en, sck_oe, sdo_oe}, 0);
        buf_wdata = 8'h11; buf_wr = 1; @(negedge clk); buf_wr = 0;
        cfg_en = 1;
        toggles = 0; prev = sck_out;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (sck_out != prev) toggles++;
            prev = sck_out;
        end
        chk(toggles == 0 && !done, "R6 write ignored", toggles, 0);
        finish_run();
    end
endmodule